// File: doc/BRIEF.md
# Two-Slot Transmit Byte Queue for a Serial-Bus Controller

This block sits between a register-bus write path and the shift engine of a two-wire serial controller. Software pushes outgoing bytes into it, either one at a time or two at a time in a single 16-bit write. The shift engine takes them out in arrival order through a valid/ready port. The queue holds at most two bytes.

Next to the data path, the block keeps an occupancy count and a level status flag. That flag compares the count against one of two selectable thresholds, and each rising edge of it gives a one-cycle interrupt pulse. A sticky overflow flag records any attempt to push more bytes than the queue can take. A clear command throws away everything that is queued.

The write side has no back-pressure. A write strobe is always taken in its cycle, and any byte with no free slot is dropped and recorded as an overflow. The read side uses valid/ready. `pop_valid` is high whenever at least one byte is queued, and `pop_data` shows the oldest byte. A byte leaves only in a cycle where `pop_valid` and `pop_ready` are both high. While `pop_ready` is low, the offered byte stays put.

Top module: `i2c_txbuf`

## Requirements
- R1: After reset the queue is empty: `fill_cnt` is 0, `pop_valid` is 0, `lvl_flag` is 1, and `lvl_irq` and `ovf_flag` are 0.
- R2: A `wr_one_en` strobe queues `wr_one_data`. Bytes leave in arrival order through `pop_data`, one per cycle in which `pop_valid` and `pop_ready` are both high. While `pop_ready` is low, `pop_data` holds its value.
- R3: A `wr_two_en` strobe queues two bytes. The byte in bits 7:0 of `wr_two_data` is queued first and the byte in bits 15:8 second.
- R4: `fill_cnt` is the number of queued bytes, 0 to 2, one cycle after the edge. A pop in the same cycle as a write frees its slot for that write.
- R5: When `lvl_mode` is 0 (empty threshold), `lvl_flag` is 1 exactly when the queue is empty.
- R6: When `lvl_mode` is 1 (half threshold), `lvl_flag` is 1 whenever the queue holds one byte or none. It drops to 0 only while the queue is full.
- R7: If a write carries more bytes than there are free slots (counting a same-cycle pop), `ovf_flag` becomes 1. The excess bytes are dropped and the bytes already stored stay unchanged. A dual write with one free slot keeps its low byte only.
- R8: `ovf_flag` stays 1 until a cycle with `ovf_clr` high clears it. If an overflow happens in that same cycle, the flag stays 1.
- R9: A `clear_tx` cycle empties the queue. Writes in that same cycle are dropped and do not raise `ovf_flag`.
- R10: Each 0-to-1 change of `lvl_flag` is accompanied by `lvl_irq` high for exactly that one cycle. `lvl_irq` is never high at any other time.
- R11: When `wr_one_en` and `wr_two_en` are high together, only the dual write is taken and `wr_one_data` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_one_en | input | 1 | Single-byte write strobe |
| wr_one_data | input | 8 | Single-byte write value |
| wr_two_en | input | 1 | Dual-byte write strobe |
| wr_two_data | input | 16 | Dual-byte value, bits 7:0 queued first |
| clear_tx | input | 1 | Discard all queued bytes |
| ovf_clr | input | 1 | Write-1 clear of the overflow flag |
| lvl_mode | input | 1 | Threshold select: 0 empty, 1 half |
| pop_valid | output | 1 | A byte is offered to the shift engine |
| pop_ready | input | 1 | Shift engine accepts the offered byte |
| pop_data | output | 8 | Oldest queued byte |
| fill_cnt | output | 2 | Number of queued bytes |
| lvl_flag | output | 1 | Level status against the selected threshold |
| lvl_irq | output | 1 | One-cycle pulse on a rising level flag |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The hardest situation to reach is a single cycle where several things meet: a dual write arrives with exactly one slot free, a pop frees a second slot, and a clear may also be present. Whether the high byte survives and whether overflow rises depends on all of these together. The bench preloads every legal fill level in both threshold modes. It then applies each combination of write kind, pop and clear in one cycle, and drains the queue to compare every surviving byte against an arithmetic model.

// File: rtl/i2c_txbuf_pkg.sv
package i2c_txbuf_pkg;
  // threshold select for the level status flag
  typedef enum logic {
    LVL_EMPTY = 1'b0,
    LVL_HALF  = 1'b1
  } lvl_mode_e;
endpackage

// File: rtl/i2c_txbuf_admit.sv
// Decides how many of the bytes offered this cycle fit, and flags the rest.
module i2c_txbuf_admit #(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic             pop_fire,
  input  logic             wr_one_en,
  input  logic             wr_two_en,
  input  logic             clear,
  output logic [CNT_W-1:0] n_take,
  output logic             ovf_evt
);
  logic [CNT_W:0] req;
  logic [CNT_W:0] space;

  always_comb begin
    if (clear)          req = '0;
    else if (wr_two_en) req = (CNT_W+1)'(2);
    else if (wr_one_en) req = (CNT_W+1)'(1);
    else                req = '0;
    space   = (CNT_W+1)'(DEPTH) - {1'b0, cnt} + (CNT_W+1)'(pop_fire);
    ovf_evt = (req > space);
    n_take  = ovf_evt ? space[CNT_W-1:0] : req[CNT_W-1:0];
  end
endmodule

// File: rtl/i2c_txbuf_store.sv
// Circular slot storage with a read pointer and an occupancy count.
module i2c_txbuf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              pop_fire,
  input  logic [CNT_W-1:0]  n_take,
  input  logic [DATA_W-1:0] byte0,
  input  logic [DATA_W-1:0] byte1,
  output logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  cnt_nxt,
  output logic [DATA_W-1:0] head
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  wr_base;
  logic [PTR_W-1:0]  wr_next;

  // DEPTH is a power of two, so pointer arithmetic wraps naturally
  assign wr_base = rd_ptr_q + PTR_W'(cnt_q);
  assign wr_next = wr_base + PTR_W'(1);

  assign cnt_nxt = clear ? '0 : (cnt_q - CNT_W'(pop_fire) + n_take);

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!clear) begin
        if (n_take != '0 && wr_base == PTR_W'(g))
          slot_q[g] <= byte0;
        else if (n_take >= CNT_W'(2) && wr_next == PTR_W'(g))
          slot_q[g] <= byte1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      rd_ptr_q <= '0;
    end else begin
      cnt_q    <= cnt_nxt;
      rd_ptr_q <= clear ? '0 : rd_ptr_q + PTR_W'(pop_fire);
    end
  end

  assign cnt  = cnt_q;
  assign head = slot_q[rd_ptr_q];

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  // R9
  clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));
endmodule

// File: rtl/i2c_txbuf_status.sv
// Level flag with selectable threshold, its edge pulse, and sticky overflow.
module i2c_txbuf_status
  import i2c_txbuf_pkg::*;
#(
  parameter int DEPTH = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  lvl_mode_e        mode,
  input  logic             ovf_evt,
  input  logic             ovf_clr,
  output logic             lvl_flag,
  output logic             lvl_irq,
  output logic             ovf_flag
);
  logic lvl_q, irq_q, ovf_q;
  logic lvl_nxt;

  always_comb begin
    if (mode == LVL_HALF) lvl_nxt = (cnt_nxt <= CNT_W'(DEPTH / 2));
    else                  lvl_nxt = (cnt_nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      irq_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      lvl_q <= lvl_nxt;
      irq_q <= lvl_nxt & ~lvl_q;
      ovf_q <= (ovf_q & ~ovf_clr) | ovf_evt;
    end
  end

  assign lvl_flag = lvl_q;
  assign lvl_irq  = irq_q;
  assign ovf_flag = ovf_q;

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);
endmodule

// File: rtl/i2c_txbuf.sv
// Two-slot transmit byte queue: single/dual writes in, valid/ready bytes out.
module i2c_txbuf
  import i2c_txbuf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_one_en,
  input  logic [DATA_W-1:0]   wr_one_data,
  input  logic                wr_two_en,
  input  logic [2*DATA_W-1:0] wr_two_data,
  input  logic                clear_tx,
  input  logic                ovf_clr,
  input  logic                lvl_mode,
  output logic                pop_valid,
  input  logic                pop_ready,
  output logic [DATA_W-1:0]   pop_data,
  output logic [CNT_W-1:0]    fill_cnt,
  output logic                lvl_flag,
  output logic                lvl_irq,
  output logic                ovf_flag
);
  logic              pop_fire;
  logic [CNT_W-1:0]  cnt, cnt_nxt, n_take;
  logic              ovf_evt;
  logic [DATA_W-1:0] byte0, byte1;

  assign pop_valid = (cnt != '0);
  assign pop_fire  = pop_valid & pop_ready;
  assign fill_cnt  = cnt;

  // dual write wins over a coincident single write
  assign byte0 = wr_two_en ? wr_two_data[DATA_W-1:0] : wr_one_data;
  assign byte1 = wr_two_data[2*DATA_W-1:DATA_W];

  i2c_txbuf_admit #(.DEPTH(DEPTH)) admit_i (
    .cnt      (cnt),
    .pop_fire (pop_fire),
    .wr_one_en(wr_one_en),
    .wr_two_en(wr_two_en),
    .clear    (clear_tx),
    .n_take   (n_take),
    .ovf_evt  (ovf_evt)
  );

  i2c_txbuf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear_tx),
    .pop_fire(pop_fire),
    .n_take  (n_take),
    .byte0   (byte0),
    .byte1   (byte1),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .head    (pop_data)
  );

  i2c_txbuf_status #(.DEPTH(DEPTH)) status_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_nxt (cnt_nxt),
    .mode    (lvl_mode_e'(lvl_mode)),
    .ovf_evt (ovf_evt),
    .ovf_clr (ovf_clr),
    .lvl_flag(lvl_flag),
    .lvl_irq (lvl_irq),
    .ovf_flag(ovf_flag)
  );

  // R2
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_ready && !clear_tx) |=> (pop_valid && $stable(pop_data)));

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(wr_one_en || wr_two_en));

  // R5
  lvl_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lvl_mode) |-> (lvl_flag == (fill_cnt == '0)));

  // R6
  lvl_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lvl_mode) |-> (lvl_flag == (fill_cnt <= CNT_W'(DEPTH / 2))));

  // R10
  irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_irq |-> (lvl_flag && !$past(lvl_flag)));
endmodule

// File: tb/i2c_txbuf_tb_top.sv
module i2c_txbuf_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_one_en = 1'b0;
  logic [7:0]  wr_one_data = '0;
  logic        wr_two_en = 1'b0;
  logic [15:0] wr_two_data = '0;
  logic        clear_tx = 1'b0;
  logic        ovf_clr = 1'b0;
  logic        lvl_mode = 1'b0;
  logic        pop_valid;
  logic        pop_ready = 1'b0;
  logic [7:0]  pop_data;
  logic [1:0]  fill_cnt;
  logic        lvl_flag, lvl_irq, ovf_flag;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_txbuf dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_one_en(wr_one_en), .wr_one_data(wr_one_data),
    .wr_two_en(wr_two_en), .wr_two_data(wr_two_data),
    .clear_tx(clear_tx), .ovf_clr(ovf_clr), .lvl_mode(lvl_mode),
    .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
    .fill_cnt(fill_cnt), .lvl_flag(lvl_flag), .lvl_irq(lvl_irq),
    .ovf_flag(ovf_flag)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int lvl_of(input int mode, input int n);
    return (mode != 0) ? int'(n <= 1) : int'(n == 0);
  endfunction

  initial begin
    int q[4];
    int n, seed, req, space, ovf_exp, lb, la, b0, b1, one_v;
    string tg;
    @(negedge clk);
    step();
    // R1 reset state
    chk("R1", "fill_cnt", fill_cnt, 0);
    chk("R1", "pop_valid", pop_valid, 0);
    chk("R1", "lvl_flag", lvl_flag, 1);
    chk("R1", "lvl_irq", lvl_irq, 0);
    chk("R1", "ovf_flag", ovf_flag, 0);
    rst_n = 1'b1;
    step();

    for (int mode = 0; mode < 2; mode++)
      for (int c0 = 0; c0 < 3; c0++)
        for (int wk = 0; wk < 4; wk++)
          for (int p = 0; p < 2; p++)
            for (int cl = 0; cl < 2; cl++) begin
              seed = (mode * 97 + c0 * 41 + wk * 13 + p * 7 + cl * 3 + 5) & 255;
              lvl_mode = 1'(mode);
              clear_tx = 1'b1; ovf_clr = 1'b1;
              step();
              clear_tx = 1'b0; ovf_clr = 1'b0;
              for (int i = 0; i < c0; i++) begin
                wr_one_en = 1'b1; wr_one_data = 8'((seed + i * 29) & 255);
                q[i] = (seed + i * 29) & 255;
                step();
              end
              wr_one_en = 1'b0;
              step();
              n = c0;
              chk("R4", "preload count", fill_cnt, n);
              chk("R7", "no ovf after legal fill", ovf_flag, 0);
              if (n > 0) chk("R2", "head byte", pop_data, q[0]);
              lb = lvl_of(mode, n);
              chk(mode ? "R6" : "R5", "level before op", lvl_flag, lb);

              b0 = (seed + 8'h11) & 255;
              b1 = (seed + 8'h33) & 255;
              one_v = (seed ^ 8'h5A) & 255;
              wr_one_en   = (wk == 1 || wk == 3);
              wr_two_en   = (wk >= 2);
              wr_one_data = 8'(one_v);
              wr_two_data = {8'(b1), 8'(b0)};
              pop_ready   = 1'(p);
              clear_tx    = 1'(cl);
              step();
              wr_one_en = 1'b0; wr_two_en = 1'b0; pop_ready = 1'b0; clear_tx = 1'b0;

              // model
              if (p != 0 && n > 0) begin
                for (int i = 0; i < n - 1; i++) q[i] = q[i + 1];
                n--;
              end
              ovf_exp = 0;
              if (cl != 0) n = 0;
              else begin
                req = (wk >= 2) ? 2 : (wk == 1) ? 1 : 0;
                space = 2 - n;
                ovf_exp = int'(req > space);
                if (req >= 1 && space >= 1) begin
                  q[n] = (wk >= 2) ? b0 : one_v; n++;
                end
                if (req >= 2 && space >= 2) begin
                  q[n] = b1; n++;
                end
              end
              tg = (cl != 0) ? "R9" : (wk == 3) ? "R11" : (wk == 2) ? "R3" : "R4";
              chk(tg, "count after op", fill_cnt, n);
              chk((cl != 0) ? "R9" : "R7", "ovf after op", ovf_flag, ovf_exp);
              la = lvl_of(mode, n);
              chk(mode ? "R6" : "R5", "level after op", lvl_flag, la);
              chk("R10", "irq on op", lvl_irq, int'(lb == 0 && la == 1));
              step();
              chk("R10", "irq one cycle", lvl_irq, 0);
              chk("R8", "ovf sticky", ovf_flag, ovf_exp);

              pop_ready = 1'b1;
              for (int i = 0; i < n; i++) begin
                chk(tg, "drain valid", pop_valid, 1);
                chk((wk >= 2 && cl == 0) ? tg : "R2", "drain byte", pop_data, q[i]);
                step();
              end
              pop_ready = 1'b0;
              chk("R2", "empty after drain", pop_valid, 0);
              chk("R4", "count after drain", fill_cnt, 0);
            end

    // R8 clear and collision
    lvl_mode = 1'b0;
    clear_tx = 1'b1; ovf_clr = 1'b1; step();
    clear_tx = 1'b0; ovf_clr = 1'b0;
    wr_two_en = 1'b1; wr_two_data = 16'hB2A1; step();
    wr_two_en = 1'b0;
    wr_one_en = 1'b1; wr_one_data = 8'hCC; step();
    wr_one_en = 1'b0;
    chk("R7", "overflow set", ovf_flag, 1);
    chk("R7", "stored kept", pop_data, 8'hA1);
    step(); step();
    chk("R8", "held without clear", ovf_flag, 1);
    ovf_clr = 1'b1; step();
    ovf_clr = 1'b0;
    chk("R8", "cleared by write-1", ovf_flag, 0);
    ovf_clr = 1'b1; wr_one_en = 1'b1; step();
    ovf_clr = 1'b0; wr_one_en = 1'b0;
    chk("R8", "set wins over clear", ovf_flag, 1);
    pop_ready = 1'b1; step();
    chk("R7", "second stored byte", pop_data, 8'hB2);
    step();
    pop_ready = 1'b0;
    chk("R4", "empty", fill_cnt, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule